// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware events for profiling. It holds four programmable 32-bit event counters and one dedicated 32-bit clock-cycle counter. Each event counter is bound to an 8-bit event code and advances on the matching bit of a vector of one-cycle event pulses. Software reaches every register through a small synchronous read/write port. The event counters are reached indirectly: software first picks a counter with a selector register, then reads or writes that counter's event-type and count registers.

Counters and interrupts are switched on and off through separate set-style and clear-style registers, one bit per counter. Bit 31 of each of those registers stands for the cycle counter. Every counter wraps from all ones to zero and latches an overflow flag when it does. To sample every R events, software loads the negative of R, so the counter wraps after exactly R events. A single interrupt line reports overflows whose interrupt is enabled. The cycle counter can be slowed to one step per 64 clocks, and it can be frozen while a debug-halt input is high.

Top module: `perf_counter_unit`

## Requirements
- R1: After synchronous reset, all counters, event types, counter enables, interrupt enables, overflow flags, the selector and the stored control bits are zero, and `irq` is low.
- R2: The control register (address 0) stores write bits 0 (global enable), 3 (cycle divide-by-64), 4 (spare) and 5 (halt stop). Bits 1 and 2 always read as 0. Bits 15:11 read as the counter count, 4. All other bits read as 0.
- R3: A write to counter-enable-set (address 1) turns on each counter whose bit is 1. A write to counter-enable-clear (address 2) turns off each counter whose bit is 1. Zero bits change nothing. Only bits 3:0 (event counters) and bit 31 (cycle counter) exist. Both addresses read back the enable mask.
- R4: Interrupt-enable-set (address 3) and interrupt-enable-clear (address 4) follow the rule of R3, with the same bit positions, and both read back the interrupt mask.
- R5: An event counter adds one in each clock in which the global enable, its own enable bit, and the `event_pulses` bit indexed by its event type are all 1. Codes 0x01 to 0x1D each select their own pulse bit. When the global enable is 0, no counter moves.
- R6: A write to the software-increment register (address 6) adds one to each enabled event counter whose bit is 1 in the written word and whose event type is 0x00. `event_pulses[0]` never advances a counter.
- R7: A write to the selector (address 7) with a value below 4 chooses the counter reached by the event-type register (address 9) and the count register (address 10). A write of 4 or more leaves the selector unchanged.
- R8: Any counter that steps from 0xFFFFFFFF wraps to 0 and sets its overflow flag. The overflow register is at address 5, with bit n for event counter n and bit 31 for the cycle counter. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R9: If a count write and an increment of the same counter fall in one clock, the written value is kept.
- R10: Writing control bit 1 zeroes every event counter in that clock. Writing control bit 2 zeroes the cycle counter and its prescaler in that clock.
- R11: The cycle counter (address 8) advances every clock while the global enable and enable bit 31 are set. With control bit 3 set, it advances once every 64 such clocks, the first step coming 64 clocks after a cycle-counter reset.
- R12: While control bit 5 and `debug_halt` are both 1, the cycle counter holds its value. The event counters keep counting.
- R13: `irq` goes high one clock after an overflow flag and its interrupt enable bit are both set. It drops one clock after no such pair remains.
- R14: A read takes one clock: `rdata` shows, in the clock after `rd_en`, the register value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| event_pulses | input | 32 | One-cycle event pulses, indexed by event code |
| debug_halt | input | 1 | Debug halt indication |
| irq | output | 1 | Registered overflow interrupt |

## Verification
Some properties are checked on every clock by the assertions. These are the per-counter step, hold, load-priority and clear rules; the cycle counter's hold between prescaler ticks and its wrap to zero; overflow set and write-one-to-clear; the ignored out-of-range selector; and the halt freeze. Other behaviour can only be shown by the bench's scenarios. This covers read-back encodings, the software increment mask combined with event type and enable, the exact divide-by-64 count, and the interrupt's rise and fall timing. It also covers the random preload runs that cross the wrap boundary.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int DATA_W = 32;
  localparam int CYC_BIT = 31;
  localparam int NUM_FIELD_LSB = 11;
  localparam int NUM_FIELD_W = 5;

  // control bit positions
  localparam int CTL_GLOBAL = 0;
  localparam int CTL_ZERO_EVT = 1;
  localparam int CTL_ZERO_CYC = 2;
  localparam int CTL_DIV64 = 3;
  localparam int CTL_HALT_STOP = 5;
  localparam logic [5:0] CTL_STORE_MASK = 6'b111001;

  typedef enum logic [3:0] {
    RA_CTRL    = 4'd0,
    RA_CEN_SET = 4'd1,
    RA_CEN_CLR = 4'd2,
    RA_IEN_SET = 4'd3,
    RA_IEN_CLR = 4'd4,
    RA_OVF     = 4'd5,
    RA_SWINC   = 4'd6,
    RA_SEL     = 4'd7,
    RA_CYC     = 4'd8,
    RA_TYPE    = 4'd9,
    RA_CNT     = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/pcu_event_counter.sv
module pcu_event_counter import pcu_pkg::*; #(
  parameter int NUM_EVT = 32,
  parameter int CODE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              type_we,
  input  logic [CODE_W-1:0] type_wdata,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              clear,
  input  logic [NUM_EVT-1:0] evt,
  input  logic              sw_hit,
  output logic [DATA_W-1:0] count,
  output logic [CODE_W-1:0] evt_type,
  output logic              wrapped
);
  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic hit;
  logic inc;

  // code zero is driven only by software increments
  always_comb begin
    hit = 1'b0;
    if (evt_type == '0)
      hit = sw_hit;
    else if (int'(evt_type) < NUM_EVT)
      hit = evt[evt_type[IDX_W-1:0]];
  end

  assign inc     = enable & hit;
  assign wrapped = inc & ~load & ~clear & (count == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      evt_type <= '0;
    end else begin
      if (type_we)
        evt_type <= type_wdata;
      if (load)
        count <= load_val;
      else if (clear)
        count <= '0;
      else if (inc)
        count <= count + 1'b1;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !clear && !inc) |=> $stable(count)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && !clear) |=> (count == $past(count) + 32'd1)); // R5
  AST_CNT_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val))); // R9
  AST_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (clear && !load) |=> (count == '0)); // R10
endmodule

// File: rtl/pcu_cycle_counter.sv
module pcu_cycle_counter import pcu_pkg::*; #(
  parameter int PRE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              div_mode,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              clear,
  output logic [DATA_W-1:0] count,
  output logic              wrapped
);
  logic [PRE_W-1:0] pre_q;
  logic tick;
  logic inc;

  assign tick    = ~div_mode | (pre_q == '1);
  assign inc     = run & tick;
  assign wrapped = inc & ~load & ~clear & (count == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      pre_q <= '0;
    end else begin
      if (clear)
        pre_q <= '0;
      else if (run && div_mode)
        pre_q <= pre_q + 1'b1;
      if (load)
        count <= load_val;
      else if (clear)
        count <= '0;
      else if (inc)
        count <= count + 1'b1;
    end
  end

  AST_CYC_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (div_mode && pre_q != '1 && !load && !clear) |=> $stable(count)); // R11
  AST_CYC_PRE_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (pre_q == '0)); // R10
  AST_CYC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc && count == '1 && !load && !clear) |=> (count == '0)); // R8
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit import pcu_pkg::*; #(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 32,
  parameter int CODE_W  = 8,
  parameter int PRE_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [3:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [NUM_EVT-1:0] event_pulses,
  input  logic               debug_halt,
  output logic               irq
);
  localparam int SEL_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  // register port decode
  logic wr_ctrl, wr_cen_set, wr_cen_clr, wr_ien_set, wr_ien_clr;
  logic wr_ovf, wr_swinc, wr_sel, wr_cyc, wr_type, wr_cnt;

  assign wr_ctrl    = wr_en && (addr == RA_CTRL);
  assign wr_cen_set = wr_en && (addr == RA_CEN_SET);
  assign wr_cen_clr = wr_en && (addr == RA_CEN_CLR);
  assign wr_ien_set = wr_en && (addr == RA_IEN_SET);
  assign wr_ien_clr = wr_en && (addr == RA_IEN_CLR);
  assign wr_ovf     = wr_en && (addr == RA_OVF);
  assign wr_swinc   = wr_en && (addr == RA_SWINC);
  assign wr_sel     = wr_en && (addr == RA_SEL);
  assign wr_cyc     = wr_en && (addr == RA_CYC);
  assign wr_type    = wr_en && (addr == RA_TYPE);
  assign wr_cnt     = wr_en && (addr == RA_CNT);

  // state
  logic [5:0]         ctrl_q;
  logic [NUM_CNT-1:0] cen_q, ien_q, ovf_q;
  logic               cyc_en_q, cyc_ien_q, cyc_ovf_q;
  logic [SEL_W-1:0]   sel_q;

  logic [DATA_W-1:0]  cnt_val  [NUM_CNT];
  logic [CODE_W-1:0]  cnt_type [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_wrap;
  logic [DATA_W-1:0]  cyc_val;
  logic               cyc_wrap;
  logic               zero_evt, zero_cyc, cyc_run;

  assign zero_evt = wr_ctrl & wdata[CTL_ZERO_EVT];
  assign zero_cyc = wr_ctrl & wdata[CTL_ZERO_CYC];
  assign cyc_run  = ctrl_q[CTL_GLOBAL] & cyc_en_q &
                    ~(ctrl_q[CTL_HALT_STOP] & debug_halt);

  function automatic logic [31:0] pack_mask(input logic c, input logic [NUM_CNT-1:0] v);
    logic [31:0] r;
    r = '0;
    r[NUM_CNT-1:0] = v;
    r[CYC_BIT] = c;
    return r;
  endfunction

  // event counters
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pcu_event_counter #(.NUM_EVT(NUM_EVT), .CODE_W(CODE_W)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .enable     (ctrl_q[CTL_GLOBAL] & cen_q[i]),
      .type_we    (wr_type && (sel_q == SEL_W'(i))),
      .type_wdata (wdata[CODE_W-1:0]),
      .load       (wr_cnt && (sel_q == SEL_W'(i))),
      .load_val   (wdata),
      .clear      (zero_evt),
      .evt        (event_pulses),
      .sw_hit     (wr_swinc & wdata[i]),
      .count      (cnt_val[i]),
      .evt_type   (cnt_type[i]),
      .wrapped    (cnt_wrap[i])
    );
  end

  pcu_cycle_counter #(.PRE_W(PRE_W)) u_cyc (
    .clk      (clk),
    .rst      (rst),
    .run      (cyc_run),
    .div_mode (ctrl_q[CTL_DIV64]),
    .load     (wr_cyc),
    .load_val (wdata),
    .clear    (zero_cyc),
    .count    (cyc_val),
    .wrapped  (cyc_wrap)
  );

  // control, enables, selector
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      cen_q     <= '0;
      ien_q     <= '0;
      cyc_en_q  <= 1'b0;
      cyc_ien_q <= 1'b0;
      sel_q     <= '0;
    end else begin
      if (wr_ctrl)
        ctrl_q <= wdata[5:0] & CTL_STORE_MASK;
      if (wr_cen_set) begin
        cen_q    <= cen_q | wdata[NUM_CNT-1:0];
        cyc_en_q <= cyc_en_q | wdata[CYC_BIT];
      end
      if (wr_cen_clr) begin
        cen_q    <= cen_q & ~wdata[NUM_CNT-1:0];
        cyc_en_q <= cyc_en_q & ~wdata[CYC_BIT];
      end
      if (wr_ien_set) begin
        ien_q     <= ien_q | wdata[NUM_CNT-1:0];
        cyc_ien_q <= cyc_ien_q | wdata[CYC_BIT];
      end
      if (wr_ien_clr) begin
        ien_q     <= ien_q & ~wdata[NUM_CNT-1:0];
        cyc_ien_q <= cyc_ien_q & ~wdata[CYC_BIT];
      end
      if (wr_sel && (wdata < 32'(NUM_CNT)))
        sel_q <= wdata[SEL_W-1:0];
    end
  end

  // overflow flags: a new wrap wins over a clear in the same clock
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q     <= '0;
      cyc_ovf_q <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (cnt_wrap[i])
          ovf_q[i] <= 1'b1;
        else if (wr_ovf && wdata[i])
          ovf_q[i] <= 1'b0;
      end
      if (cyc_wrap)
        cyc_ovf_q <= 1'b1;
      else if (wr_ovf && wdata[CYC_BIT])
        cyc_ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq <= 1'b0;
    else
      irq <= (|(ovf_q & ien_q)) | (cyc_ovf_q & cyc_ien_q);
  end

  // read port
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      RA_CTRL:    rd_mux = {16'b0, NUM_FIELD_W'(NUM_CNT), 5'b0, ctrl_q};
      RA_CEN_SET,
      RA_CEN_CLR: rd_mux = pack_mask(cyc_en_q, cen_q);
      RA_IEN_SET,
      RA_IEN_CLR: rd_mux = pack_mask(cyc_ien_q, ien_q);
      RA_OVF:     rd_mux = pack_mask(cyc_ovf_q, ovf_q);
      RA_SEL:     rd_mux = 32'(sel_q);
      RA_CYC:     rd_mux = cyc_val;
      RA_TYPE:    rd_mux = 32'(cnt_type[sel_q]);
      RA_CNT:     rd_mux = cnt_val[sel_q];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
  end

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (!irq && ovf_q == '0 && !cyc_ovf_q && cen_q == '0)); // R1
  AST_CEN_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr_cen_clr && wdata[CYC_BIT]) |=> !cyc_en_q); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    cyc_wrap |=> cyc_ovf_q); // R8
  AST_OVF_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_ovf && wdata[CYC_BIT] && !cyc_wrap) |=> !cyc_ovf_q); // R8
  AST_SEL_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && wdata >= 32'(NUM_CNT)) |=> $stable(sel_q)); // R7
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CTL_HALT_STOP] && debug_halt && !wr_cyc && !zero_cyc) |=> $stable(cyc_val)); // R12
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ovf_q == '0 && !cyc_ovf_q) |=> !irq); // R13
endmodule

// File: tb/test_perf_counter_unit.sv
module test_perf_counter_unit;
  localparam logic [3:0] A_CTRL = 4'd0, A_CSET = 4'd1, A_CCLR = 4'd2, A_ISET = 4'd3,
                         A_ICLR = 4'd4, A_OVF = 4'd5, A_SWI = 4'd6, A_SEL = 4'd7,
                         A_CYC = 4'd8, A_TYPE = 4'd9, A_CNT = 4'd10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] event_pulses = '0;
  logic        debug_halt = 1'b0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  perf_counter_unit i_perf_counter_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .event_pulses(event_pulses),
    .debug_halt(debug_halt), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int code);
    event_pulses = 32'(1) << code;
    @(negedge clk);
    event_pulses = '0;
  endtask

  // expected {wrap, value} after n increments from preload p
  function automatic logic [32:0] advance(input logic [31:0] p, input int n);
    return {1'b0, p} + 33'(n);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before all requirements were checked");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b;
    logic [32:0] e;
    void'($urandom(32'h1D2C3B4A));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h0000_2000);
    rd(A_CSET, v); check("R1 cnt enables", v, 32'h0);
    rd(A_OVF, v);  check("R1 overflow", v, 32'h0);
    rd(A_SEL, v);  check("R1 selector", v, 32'h0);
    rd(A_CNT, v);  check("R1 count", v, 32'h0);
    rd(A_CYC, v);  check("R1 cycle", v, 32'h0);

    // R2 control read-back
    wr(A_CTRL, 32'hFFFF_FFC9); rd(A_CTRL, v); check("R2 ctrl upper ignored", v, 32'h0000_2009);
    wr(A_CTRL, 32'h0000_003F); rd(A_CTRL, v); check("R2 ctrl pulse bits read 0", v, 32'h0000_2039);
    wr(A_CTRL, 32'h0);

    // R3 counter enables
    wr(A_CSET, 32'hFFFF_FFFF); rd(A_CSET, v); check("R3 set all", v, 32'h8000_000F);
    wr(A_CCLR, 32'h7FFF_FFF1); rd(A_CCLR, v); check("R3 clear some", v, 32'h8000_000E);
    wr(A_CCLR, 32'hFFFF_FFFF); rd(A_CSET, v); check("R3 clear all", v, 32'h0);

    // R4 interrupt enables
    wr(A_ISET, 32'h8000_0002); rd(A_ICLR, v); check("R4 set", v, 32'h8000_0002);
    wr(A_ICLR, 32'h0);         rd(A_ISET, v); check("R4 zero bits no effect", v, 32'h8000_0002);
    wr(A_ICLR, 32'hFFFF_FFFF); rd(A_ISET, v); check("R4 clear", v, 32'h0);

    // R7 selector, R14 read latency
    wr(A_SEL, 32'd2); rd(A_SEL, v); check("R14 read after write", v, 32'd2);
    wr(A_SEL, 32'd7); rd(A_SEL, v); check("R7 out of range ignored", v, 32'd2);
    wr(A_TYPE, 32'h08);
    wr(A_SEL, 32'd1); rd(A_TYPE, v); check("R7 other counter type", v, 32'h0);
    wr(A_SEL, 32'd2); rd(A_TYPE, v); check("R7 selected type", v, 32'h08);

    // R5 event counting on counter 2
    wr(A_CNT, 32'h10); wr(A_CSET, 32'h4); wr(A_CTRL, 32'h1);
    for (int k = 0; k < 5; k++) pulse(8);
    for (int k = 0; k < 2; k++) pulse(9);
    rd(A_CNT, v); check("R5 matching code only", v, 32'h15);
    wr(A_TYPE, 32'h1D);
    for (int k = 0; k < 3; k++) pulse(29);
    rd(A_CNT, v); check("R5 highest code", v, 32'h18);
    wr(A_CTRL, 32'h0); pulse(29);
    rd(A_CNT, v); check("R5 global disable", v, 32'h18);

    // R10 zero event counters
    wr(A_CTRL, 32'h3);
    rd(A_CNT, v); check("R10 event counters zeroed", v, 32'h0);
    rd(A_CTRL, v); check("R10 zero bit reads 0", v, 32'h0000_2001);

    // R6 software increment
    wr(A_SEL, 32'd0); wr(A_TYPE, 32'h0);
    wr(A_SEL, 32'd1); wr(A_TYPE, 32'h0);
    wr(A_SEL, 32'd2); wr(A_TYPE, 32'h5);
    wr(A_SEL, 32'd3); wr(A_TYPE, 32'h0);
    wr(A_CCLR, 32'hFFFF_FFFF); wr(A_CSET, 32'hD);
    pulse(0);
    wr(A_SWI, 32'hF);
    wr(A_SEL, 32'd0); rd(A_CNT, v); check("R6 counter0 incremented", v, 32'h1);
    wr(A_SEL, 32'd1); rd(A_CNT, v); check("R6 disabled counter1 held", v, 32'h0);
    wr(A_SEL, 32'd2); rd(A_CNT, v); check("R6 non-zero type held", v, 32'h0);
    wr(A_SEL, 32'd3); rd(A_CNT, v); check("R6 counter3 incremented", v, 32'h1);

    // R9 write wins over increment
    wr(A_SEL, 32'd0); wr(A_TYPE, 32'h4);
    addr = A_CNT; wdata = 32'h100; wr_en = 1'b1; event_pulses = 32'h10;
    @(negedge clk);
    wr_en = 1'b0; event_pulses = '0;
    rd(A_CNT, v); check("R9 written value kept", v, 32'h100);
    pulse(4);
    rd(A_CNT, v); check("R9 counting resumes", v, 32'h101);

    // R8 / R13 event counter overflow and interrupt
    wr(A_SEL, 32'd1); wr(A_TYPE, 32'h11); wr(A_CNT, 32'hFFFF_FFFD);
    wr(A_OVF, 32'hFFFF_FFFF); wr(A_ISET, 32'h2); wr(A_CSET, 32'h2);
    check("R13 irq low before wrap", {31'b0, irq}, 32'h0);
    for (int k = 0; k < 3; k++) pulse(17);
    @(negedge clk);
    check("R13 irq raised", {31'b0, irq}, 32'h1);
    rd(A_OVF, v); check("R8 flag bit1", v, 32'h2);
    rd(A_CNT, v); check("R8 wrapped to zero", v, 32'h0);
    wr(A_OVF, 32'h0); rd(A_OVF, v); check("R8 zero write keeps flag", v, 32'h2);
    wr(A_OVF, 32'h2);
    @(negedge clk);
    check("R13 irq dropped", {31'b0, irq}, 32'h0);
    rd(A_OVF, v); check("R8 flag cleared", v, 32'h0);

    // R11 cycle counter
    wr(A_CTRL, 32'h5); wr(A_CSET, 32'h8000_0000);
    rd(A_CYC, a); repeat (9) @(negedge clk); rd(A_CYC, b);
    check("R11 every clock", b - a, 32'd10);
    wr(A_CTRL, 32'hD); repeat (200) @(negedge clk);
    rd(A_CYC, v); check("R11 divide by 64", v, 32'd3);

    // R12 halt stop
    wr(A_CTRL, 32'h21); debug_halt = 1'b1;
    rd(A_CYC, a); repeat (9) @(negedge clk); rd(A_CYC, b);
    check("R12 cycle frozen", b - a, 32'd0);
    wr(A_SEL, 32'd0); pulse(4);
    rd(A_CNT, v); check("R12 event counter runs", v, 32'h102);
    wr(A_CTRL, 32'h1);
    rd(A_CYC, a); repeat (9) @(negedge clk); rd(A_CYC, b);
    check("R12 halt ignored when stop off", b - a, 32'd10);
    debug_halt = 1'b0;

    // R8 cycle counter overflow at bit 31
    wr(A_OVF, 32'hFFFF_FFFF); wr(A_CYC, 32'hFFFF_FFF0);
    repeat (20) @(negedge clk);
    rd(A_OVF, v); check("R8 cycle flag bit31", v, 32'h8000_0000);

    // R5 / R8 random preloads and pulse runs
    wr(A_CCLR, 32'hFFFF_FFFF);
    for (int it = 0; it < 24; it++) begin
      int idx, code, n;
      logic [31:0] pre;
      idx  = int'($urandom % 4);
      code = 1 + int'($urandom % 29);
      pre  = ($urandom % 2 == 0) ? $urandom : (32'hFFFF_FFFF - ($urandom % 8));
      n    = int'($urandom % 12);
      wr(A_SEL, 32'(idx)); wr(A_TYPE, 32'(code)); wr(A_CNT, pre);
      wr(A_OVF, 32'hFFFF_FFFF); wr(A_CCLR, 32'hFFFF_FFFF); wr(A_CSET, 32'(1) << idx);
      for (int k = 0; k < n; k++) begin
        pulse(code);
        if ($urandom % 3 == 0) pulse(code ^ 1);
      end
      e = advance(pre, n);
      rd(A_CNT, v); check("R5 random count", v, e[31:0]);
      rd(A_OVF, v); check("R8 random flag", v, e[32] ? (32'(1) << idx) : 32'h0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule